// File: doc/BRIEF.md
# CAN Protocol Event Code Capture

This block records the outcome of every CAN protocol event seen by the protocol engine. An event is either an error or a successfully received frame. Each outcome is turned into a 3-bit code. The code is stored in one of two fields:

- The nominal field holds events from the arbitration bit rate.
- The data-phase field holds the first event that follows entry into a bit-rate-switched FD data phase.

The block also does the following:

- A stuff error at a fixed stuff position inside an FD CRC sequence is stored as a form error.
- The bus-off recovery logic can write a bit-0 error code into the nominal field once for every run of 11 recessive bits.
- When a reception completes, the block keeps the FD-format, bit-rate-switch and error-state-indicator flags of that message.

A CPU read of the status word returns both code fields to "no change". The status word collects the codes, the captured flags and the fault-confinement and activity inputs.

Top module: `can_event_status`

## Requirements
- R1: After reset both code fields read 7 and the three captured message flags read 0.
- R2: Codes are 0 none/valid, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 no change. When several error strobes are high in one cycle, the lowest code wins. Any error beats a valid-frame strobe.
- R3: A valid-frame strobe on its own writes code 0 into the field that the routing selects, one cycle after the strobe.
- R4: The data phase is entered when in_data_phase rises while fd_frame and brs_flag are both high. The next event after that entry is written into the data-phase field, and the nominal field keeps its value.
- R5: After the routed event has been written, later events go to the nominal field again, even while in_data_phase stays high.
- R6: A data phase entered without brs_flag, or without fd_frame, routes nothing. Its events go to the nominal field.
- R7: A stuff error with crc_fixed_stuff and fd_frame both high is written as code 2 (form) and never as code 1.
- R8: A recovery_bit0 pulse with no protocol event in the same cycle writes code 5 into the nominal field. If a protocol event occurs in that cycle, the event wins.
- R9: A status_rd pulse sets both code fields to 7. A field that receives an event in the same cycle takes the event code instead.
- R10: On rx_done the block captures rx_fdf, rx_brs and rx_esi. Otherwise the captured values hold.
- R11: status_word layout:
  - bits [2:0] nominal code
  - bits [4:3] activity
  - bit 5 error passive
  - bit 6 warning
  - bit 7 bus-off
  - bits [10:8] data-phase code
  - bit 11 captured ESI
  - bit 12 captured BRS
  - bit 13 captured FD format
  - bits [15:14] zero

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_stuff | input | 1 | Stuff error strobe |
| ev_form | input | 1 | Form error strobe |
| ev_ack | input | 1 | Acknowledge error strobe |
| ev_bit1 | input | 1 | Bit-1 error strobe |
| ev_bit0 | input | 1 | Bit-0 error strobe |
| ev_crc | input | 1 | CRC error strobe |
| ev_valid | input | 1 | Valid frame strobe |
| fd_frame | input | 1 | Current frame is FD format |
| brs_flag | input | 1 | Current frame has bit-rate switch set |
| in_data_phase | input | 1 | Engine is in the data phase |
| crc_fixed_stuff | input | 1 | Current bit is a fixed stuff bit in the FD CRC |
| recovery_bit0 | input | 1 | Bus-off recovery saw 11 recessive bits |
| status_rd | input | 1 | CPU read of status word |
| rx_done | input | 1 | Reception completed |
| rx_fdf | input | 1 | Received message FD format |
| rx_brs | input | 1 | Received message bit-rate switch |
| rx_esi | input | 1 | Received message error state indicator |
| bus_off | input | 1 | Bus-off state |
| err_warn | input | 1 | Error warning state |
| err_passive | input | 1 | Error passive state |
| activity | input | 2 | Activity state |
| nom_code | output | 3 | Nominal phase code |
| dat_code | output | 3 | Data phase code |
| status_word | output | 16 | Packed status |

## Verification
The embedded assertions check these rules on every cycle:
- fixed-stuff reclassification
- read-to-7 update when no event occurs
- the recovery write
- the valid-frame write
- the data-phase field holding when nothing touches it
- the captured flags holding between completions

The directed scenarios are needed to show the cross-cycle routing:
- latching at data-phase entry
- release after exactly one event
- no routing without BRS or without FD

The scenarios also show error priority between simultaneous strobes and per-field precedence when an event collides with a read.

// File: rtl/can_event_status.sv
module can_event_status (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ev_stuff,
  input  logic        ev_form,
  input  logic        ev_ack,
  input  logic        ev_bit1,
  input  logic        ev_bit0,
  input  logic        ev_crc,
  input  logic        ev_valid,
  input  logic        fd_frame,
  input  logic        brs_flag,
  input  logic        in_data_phase,
  input  logic        crc_fixed_stuff,
  input  logic        recovery_bit0,
  input  logic        status_rd,
  input  logic        rx_done,
  input  logic        rx_fdf,
  input  logic        rx_brs,
  input  logic        rx_esi,
  input  logic        bus_off,
  input  logic        err_warn,
  input  logic        err_passive,
  input  logic [1:0]  activity,
  output logic [2:0]  nom_code,
  output logic [2:0]  dat_code,
  output logic [15:0] status_word
);

  localparam logic [2:0] C_NONE  = 3'd0;
  localparam logic [2:0] C_STUFF = 3'd1;
  localparam logic [2:0] C_FORM  = 3'd2;
  localparam logic [2:0] C_ACK   = 3'd3;
  localparam logic [2:0] C_BIT1  = 3'd4;
  localparam logic [2:0] C_BIT0  = 3'd5;
  localparam logic [2:0] C_CRC   = 3'd6;
  localparam logic [2:0] C_KEEP  = 3'd7;

  logic       dp_q, route_q;
  logic       fdf_q, brs_q, esi_q;
  logic [2:0] ev_code;
  logic       any_err, any_ev, dp_entry, route_now;

  assign any_err   = ev_stuff | ev_form | ev_ack | ev_bit1 | ev_bit0 | ev_crc;
  assign any_ev    = any_err | ev_valid;
  assign dp_entry  = in_data_phase & ~dp_q & fd_frame & brs_flag;
  assign route_now = route_q | dp_entry;

  always_comb begin
    if (ev_stuff)     ev_code = (fd_frame && crc_fixed_stuff) ? C_FORM : C_STUFF;
    else if (ev_form) ev_code = C_FORM;
    else if (ev_ack)  ev_code = C_ACK;
    else if (ev_bit1) ev_code = C_BIT1;
    else if (ev_bit0) ev_code = C_BIT0;
    else if (ev_crc)  ev_code = C_CRC;
    else              ev_code = C_NONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dp_q    <= 1'b0;
      route_q <= 1'b0;
    end else begin
      dp_q    <= in_data_phase;
      route_q <= any_ev ? 1'b0 : route_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nom_code <= C_KEEP;
      dat_code <= C_KEEP;
    end else begin
      if (any_ev && !route_now)  nom_code <= ev_code;
      else if (recovery_bit0)    nom_code <= C_BIT0;
      else if (status_rd)        nom_code <= C_KEEP;
      if (any_ev && route_now)   dat_code <= ev_code;
      else if (status_rd)        dat_code <= C_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fdf_q <= 1'b0;
      brs_q <= 1'b0;
      esi_q <= 1'b0;
    end else if (rx_done) begin
      fdf_q <= rx_fdf;
      brs_q <= rx_brs;
      esi_q <= rx_esi;
    end
  end

  assign status_word = {2'b00, fdf_q, brs_q, esi_q, dat_code,
                        bus_off, err_warn, err_passive, activity, nom_code};

  assert_fixed_stuff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stuff && crc_fixed_stuff && fd_frame) |=> (nom_code == C_FORM || dat_code == C_FORM));

  assert_read_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_rd && !any_ev && !recovery_bit0) |=> (nom_code == C_KEEP && dat_code == C_KEEP));

  assert_recovery_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (recovery_bit0 && !any_ev) |=> (nom_code == C_BIT0));

  assert_valid_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !any_err) |=> (nom_code == C_NONE || dat_code == C_NONE));

  assert_dat_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_ev && !status_rd) |=> $stable(dat_code));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_done |=> $stable(status_word[13:11]));

endmodule

// File: tb/tb_can_event_status.sv
module tb_can_event_status;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0] ev = '0;
  logic fd_frame = 0, brs_flag = 0, in_data_phase = 0, crc_fixed_stuff = 0;
  logic recovery_bit0 = 0, status_rd = 0, rx_done = 0, rx_fdf = 0, rx_brs = 0, rx_esi = 0;
  logic bus_off = 0, err_warn = 0, err_passive = 0;
  logic [1:0] activity = 2'b00;
  logic [2:0] nom_code, dat_code;
  logic [15:0] status_word;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  can_event_status dut (
    .clk(clk), .rst_n(rst_n),
    .ev_stuff(ev[0]), .ev_form(ev[1]), .ev_ack(ev[2]), .ev_bit1(ev[3]),
    .ev_bit0(ev[4]), .ev_crc(ev[5]), .ev_valid(ev[6]),
    .fd_frame(fd_frame), .brs_flag(brs_flag), .in_data_phase(in_data_phase),
    .crc_fixed_stuff(crc_fixed_stuff), .recovery_bit0(recovery_bit0),
    .status_rd(status_rd), .rx_done(rx_done), .rx_fdf(rx_fdf), .rx_brs(rx_brs),
    .rx_esi(rx_esi), .bus_off(bus_off), .err_warn(err_warn), .err_passive(err_passive),
    .activity(activity), .nom_code(nom_code), .dat_code(dat_code), .status_word(status_word)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fire(input logic [6:0] e);
    ev = e;
    step();
    ev = '0;
  endtask

  task automatic enter_dp(input logic fd, input logic brs);
    fd_frame = fd; brs_flag = brs;
    step();
    in_data_phase = 1;
    step();
  endtask

  task automatic leave_dp();
    in_data_phase = 0; fd_frame = 0; brs_flag = 0;
    step();
  endtask

  task automatic t_reset();
    check("R1 nom", nom_code, 7);
    check("R1 dat", dat_code, 7);
    check("R1 flags", status_word[13:11], 0);
  endtask

  task automatic t_codes();
    for (int i = 0; i < 6; i++) begin
      fire(7'(1 << i));
      check("R2 single", nom_code, i + 1);
    end
    fire(7'b0101100);
    check("R2 priority ack", nom_code, 3);
    fire(7'b1110000);
    check("R2 error over valid", nom_code, 5);
    check("R2 dat untouched", dat_code, 7);
  endtask

  task automatic t_valid();
    fire(7'b1000000);
    check("R3 valid nominal", nom_code, 0);
  endtask

  task automatic t_route();
    fire(7'b0000100);
    check("R4 pre", nom_code, 3);
    enter_dp(1, 1);
    fire(7'b1000000);
    check("R4 dat valid", dat_code, 0);
    check("R4 nom kept", nom_code, 3);
    fire(7'b0100000);
    check("R5 back to nominal", nom_code, 6);
    check("R5 dat kept", dat_code, 0);
    leave_dp();
  endtask

  task automatic t_no_brs();
    status_rd = 1; step(); status_rd = 0;
    enter_dp(1, 0);
    fire(7'b0001000);
    check("R6 no brs nom", nom_code, 4);
    check("R6 no brs dat", dat_code, 7);
    leave_dp();
    enter_dp(0, 1);
    fire(7'b0000010);
    check("R6 classic nom", nom_code, 2);
    check("R6 classic dat", dat_code, 7);
    leave_dp();
  endtask

  task automatic t_fixed_stuff();
    fd_frame = 1; crc_fixed_stuff = 1;
    fire(7'b0000001);
    check("R7 fixed stuff", nom_code, 2);
    fd_frame = 0;
    fire(7'b0000001);
    check("R7 classic stuff", nom_code, 1);
    crc_fixed_stuff = 0;
  endtask

  task automatic t_recovery();
    recovery_bit0 = 1; step(); recovery_bit0 = 0;
    check("R8 bit0", nom_code, 5);
    recovery_bit0 = 1; fire(7'b0000100); recovery_bit0 = 0;
    check("R8 event wins", nom_code, 3);
  endtask

  task automatic t_read();
    enter_dp(1, 1);
    fire(7'b0100000);
    leave_dp();
    check("R9 setup dat", dat_code, 6);
    status_rd = 1; step(); status_rd = 0;
    check("R9 nom cleared", nom_code, 7);
    check("R9 dat cleared", dat_code, 7);
    fire(7'b0001000);
    status_rd = 1; fire(7'b0000100); status_rd = 0;
    check("R9 collision nom", nom_code, 3);
    check("R9 collision dat", dat_code, 7);
  endtask

  task automatic t_rx();
    rx_fdf = 1; rx_brs = 0; rx_esi = 1; rx_done = 1; step(); rx_done = 0;
    check("R10 capture", status_word[13:11], 3'b101);
    rx_fdf = 0; rx_brs = 1; rx_esi = 0; step();
    check("R10 hold", status_word[13:11], 3'b101);
  endtask

  task automatic t_word();
    bus_off = 1; err_warn = 0; err_passive = 1; activity = 2'b10; step();
    check("R11 bo", status_word[7], 1);
    check("R11 ew", status_word[6], 0);
    check("R11 ep", status_word[5], 1);
    check("R11 act", status_word[4:3], 2);
    check("R11 nom", status_word[2:0], nom_code);
    check("R11 dat", status_word[10:8], dat_code);
    check("R11 zero", status_word[15:14], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    step();
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_codes();
    t_valid();
    t_route();
    t_no_brs();
    t_fixed_stuff();
    t_recovery();
    t_read();
    t_rx();
    t_word();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule